// File: doc/BRIEF.md
# Block-Protocol I2C Configuration Slave

This block is the serial control port of a clock-generator control bank. It listens on a two-wire I2C bus as a slave at one fixed 7-bit address. It keeps a small bank of byte-wide control registers and drives them out as a parallel vector to the rest of the chip. The bus lines are sampled into the system clock domain. SDA is driven open-drain: a single output enable pulls the line low, and nothing else drives it. SCL is only ever observed.

A write transfer is a block write. After the address, the master sends a command byte and a count byte. The slave acknowledges both and throws them away. Every byte after that lands in the next control register, counting up from register 0. A read transfer has no register pointer. The slave answers with a fixed count byte, then every register in order, including one read-only byte that is taken from an input port. A transfer can end after any whole byte. Registers that the transfer did not reach keep their contents.

Top module: `i2c_blockcfg_slave`

## Requirements
- R1: The slave acknowledges an address byte of 0xD2 (write) or 0xD3 (read), which is 7-bit address 0x69. Any other address is not acknowledged, and the slave leaves SDA released for the rest of that transfer, data bytes included, until the next START or STOP.
- R2: In a write, the two bytes that follow the address are each acknowledged. Neither value reaches any register.
- R3: From the third byte of a write onward, each byte is acknowledged and stored in turn into register 0, then 1, and so on up to register 5. `cfg_o[8*k+7:8*k]` presents register k.
- R4: A STOP ends loading. A byte that was cut off before its eighth bit is not stored, and registers the write did not reach keep their previous values.
- R5: Write data bytes past register 5 are still acknowledged but are not stored anywhere.
- R6: A read returns a count byte of value 7 first, then registers 0 to 5, then the read-only byte.
- R7: The read-only byte, the seventh byte after the count, equals `ro_byte_i`. Every byte the master reads after it is 0xFF.
- R8: When the master does not acknowledge a read byte, the slave releases SDA and keeps it released, even if SCL keeps toggling, until a STOP or START.
- R9: After reset, register k holds 0x10+k (0x10 to 0x15) and SDA is released.
- R10: Data goes MSB first in both directions. The slave changes SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| ro_byte_i | input | 8 | Read-only byte returned after register 5 |
| cfg_o | output | 48 | Control registers, register k in bits 8k+7..8k |

## Verification
The bench builds the block with its default parameters: six writable registers, one read-only byte, two synchronizer stages and address 0x69. At that size a single write of eight data bytes runs past the last writable register. A read of nine bytes runs through the count, every register, the read-only byte and the 0xFF tail. Short transfers are enough to reach overrun, truncation mid-byte and the master-NACK abort. The slow bus against the fast system clock makes any SDA change while SCL is high easy to see.

// File: rtl/cfg_bus_pkg.sv
package cfg_bus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_WAIT
    } slv_state_e;

    typedef struct packed {
        logic scl_s;
        logic sda_s;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import cfg_bus_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);

    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d          = q;
        d.scl_sh   = {q.scl_sh[STAGES-2:0], scl_i};
        d.sda_sh   = {q.sda_sh[STAGES-2:0], sda_i};
        d.scl_prev = q.scl_sh[STAGES-1];
        d.sda_prev = q.sda_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    logic scl_now, sda_now;
    assign scl_now = q.scl_sh[STAGES-1];
    assign sda_now = q.sda_sh[STAGES-1];

    always_comb begin
        ev_o.scl_s    = scl_now;
        ev_o.sda_s    = sda_now;
        ev_o.scl_rise = scl_now & ~q.scl_prev;
        ev_o.scl_fall = ~scl_now & q.scl_prev;
        ev_o.start    = scl_now & q.scl_prev & q.sda_prev & ~sda_now;
        ev_o.stop     = scl_now & q.scl_prev & ~q.sda_prev & sda_now;
    end

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank #(
    parameter int                  NUM_WR   = 6,
    parameter int                  NUM_RD   = 7,
    parameter int                  IDXW     = 4,
    parameter logic [NUM_WR*8-1:0] DEFAULTS = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we_i,
    input  logic [IDXW-1:0]              waddr_i,
    input  logic [7:0]                   wdata_i,
    input  logic [IDXW-1:0]              raddr_i,
    output logic [7:0]                   rdata_o,
    input  logic [(NUM_RD-NUM_WR)*8-1:0] ro_i,
    output logic [NUM_WR*8-1:0]          cfg_o
);

    localparam int RD_BITS = NUM_RD * 8;

    logic [NUM_WR*8-1:0] regs_q, regs_d;
    logic [RD_BITS-1:0]  view;

    always_comb begin
        regs_d = regs_q;
        for (int k = 0; k < NUM_WR; k++) begin
            if (we_i && waddr_i == IDXW'(k)) regs_d[k*8 +: 8] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= DEFAULTS;
        else        regs_q <= regs_d;
    end

    assign cfg_o = regs_q;
    assign view  = {ro_i, regs_q};

    always_comb begin
        rdata_o = 8'hFF;
        for (int k = 0; k < NUM_RD; k++) begin
            if (raddr_i == IDXW'(k)) rdata_o = view[k*8 +: 8];
        end
    end

    // write strobes only ever target a writable register
    assert_wr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> (waddr_i < IDXW'(NUM_WR)));

    // without a write strobe the bank holds its contents
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(cfg_o));

endmodule

// File: rtl/i2c_block_fsm.sv
module i2c_block_fsm
    import cfg_bus_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NUM_WR   = 6,
    parameter int         NUM_RD   = 7,
    parameter int         IDXW     = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  bus_ev_t         ev_i,
    output logic            sda_oe_o,
    output logic            we_o,
    output logic [IDXW-1:0] waddr_o,
    output logic [7:0]      wdata_o,
    output logic [IDXW-1:0] raddr_o,
    input  logic [7:0]      rdata_i
);

    localparam int DUMMY = 2;

    typedef struct packed {
        slv_state_e      st;
        logic [3:0]      bitc;
        logic [7:0]      sh;
        logic [IDXW-1:0] wcnt;
        logic [IDXW-1:0] rptr;
        logic            mnack;
        logic            oe;
    } fsm_t;

    fsm_t q, d;

    always_comb begin
        d       = q;
        we_o    = 1'b0;
        waddr_o = '0;
        wdata_o = q.sh;
        if (ev_i.stop) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (ev_i.start) begin
            d.st   = ST_ADDR;
            d.bitc = 4'd0;
            d.oe   = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR: begin
                    if (ev_i.scl_rise && q.bitc < 4'd8) begin
                        d.sh   = {q.sh[6:0], ev_i.sda_s};
                        d.bitc = q.bitc + 4'd1;
                    end else if (ev_i.scl_fall && q.bitc == 4'd8) begin
                        if (q.sh[7:1] == DEV_ADDR) begin
                            d.oe = 1'b1;
                            d.st = ST_ADDR_ACK;
                        end else begin
                            d.st = ST_WAIT;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (ev_i.scl_fall) begin
                        d.bitc = 4'd0;
                        if (q.sh[0]) begin
                            d.st   = ST_RD_BYTE;
                            d.sh   = 8'(NUM_RD);
                            d.oe   = ~d.sh[7];
                            d.rptr = '0;
                        end else begin
                            d.st   = ST_WR_BYTE;
                            d.oe   = 1'b0;
                            d.wcnt = '0;
                        end
                    end
                end
                ST_WR_BYTE: begin
                    if (ev_i.scl_rise && q.bitc < 4'd8) begin
                        d.sh   = {q.sh[6:0], ev_i.sda_s};
                        d.bitc = q.bitc + 4'd1;
                    end else if (ev_i.scl_fall && q.bitc == 4'd8) begin
                        d.oe = 1'b1;
                        d.st = ST_WR_ACK;
                        if (q.wcnt >= IDXW'(DUMMY) && q.wcnt < IDXW'(NUM_WR + DUMMY)) begin
                            we_o    = 1'b1;
                            waddr_o = q.wcnt - IDXW'(DUMMY);
                        end
                        if (q.wcnt != '1) d.wcnt = q.wcnt + 1'b1;
                    end
                end
                ST_WR_ACK: begin
                    if (ev_i.scl_fall) begin
                        d.oe   = 1'b0;
                        d.st   = ST_WR_BYTE;
                        d.bitc = 4'd0;
                    end
                end
                ST_RD_BYTE: begin
                    if (ev_i.scl_rise && q.bitc < 4'd8) begin
                        d.bitc = q.bitc + 4'd1;
                    end else if (ev_i.scl_fall && q.bitc == 4'd8) begin
                        d.oe = 1'b0;
                        d.st = ST_RD_ACK;
                    end else if (ev_i.scl_fall && q.bitc != 4'd0) begin
                        d.sh = {q.sh[6:0], 1'b0};
                        d.oe = ~q.sh[6];
                    end
                end
                ST_RD_ACK: begin
                    if (ev_i.scl_rise) begin
                        d.mnack = ev_i.sda_s;
                    end else if (ev_i.scl_fall) begin
                        if (q.mnack) begin
                            d.st = ST_WAIT;
                            d.oe = 1'b0;
                        end else begin
                            d.sh   = rdata_i;
                            d.oe   = ~rdata_i[7];
                            d.st   = ST_RD_BYTE;
                            d.bitc = 4'd0;
                            if (q.rptr != '1) d.rptr = q.rptr + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;
    assign raddr_o  = q.rptr;

    // SDA may only move while SCL is low, except when a START/STOP clears the bus
    assert_sda_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(q.oe) && !$past(ev_i.start) && !$past(ev_i.stop)) |-> !$past(ev_i.scl_s));

    // a START always restarts address reception
    assert_start_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i.start |=> (q.st == ST_ADDR && q.bitc == 4'd0));

    // a STOP always leaves the bus released and idle
    assert_stop_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i.stop |=> (q.st == ST_IDLE && !sda_oe_o));

    // once parked in the wait state, SDA stays released
    assert_wait_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAIT) |-> !sda_oe_o);

endmodule

// File: rtl/i2c_blockcfg_slave.sv
module i2c_blockcfg_slave
    import cfg_bus_pkg::*;
#(
    parameter logic [6:0]          DEV_ADDR    = 7'h69,
    parameter int                  NUM_WR      = 6,
    parameter int                  NUM_RD      = 7,
    parameter int                  SYNC_STAGES = 2,
    parameter logic [NUM_WR*8-1:0] DEFAULTS    = 48'h15_14_13_12_11_10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         scl_i,
    input  logic                         sda_i,
    output logic                         sda_oe_o,
    input  logic [(NUM_RD-NUM_WR)*8-1:0] ro_byte_i,
    output logic [NUM_WR*8-1:0]          cfg_o
);

    localparam int IDXW = $clog2(NUM_RD + 3);

    bus_ev_t         ev;
    logic            we;
    logic [IDXW-1:0] waddr, raddr;
    logic [7:0]      wdata, rdata;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    i2c_block_fsm #(
        .DEV_ADDR (DEV_ADDR),
        .NUM_WR   (NUM_WR),
        .NUM_RD   (NUM_RD),
        .IDXW     (IDXW)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_i     (ev),
        .sda_oe_o (sda_oe_o),
        .we_o     (we),
        .waddr_o  (waddr),
        .wdata_o  (wdata),
        .raddr_o  (raddr),
        .rdata_i  (rdata)
    );

    cfg_regbank #(
        .NUM_WR   (NUM_WR),
        .NUM_RD   (NUM_RD),
        .IDXW     (IDXW),
        .DEFAULTS (DEFAULTS)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we),
        .waddr_i (waddr),
        .wdata_i (wdata),
        .raddr_i (raddr),
        .rdata_o (rdata),
        .ro_i    (ro_byte_i),
        .cfg_o   (cfg_o)
    );

endmodule

// File: tb/i2c_blockcfg_slave_test.sv
module i2c_blockcfg_slave_test;

    localparam int          Q   = 20;
    localparam logic [47:0] DEF = 48'h15_14_13_12_11_10;
    localparam logic [7:0]  RO  = 8'h3C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_low = 1'b0, sda_low = 1'b0;
    logic sda_oe;
    logic [47:0] cfg;
    logic scl_line, sda_line;

    always #2.5 clk = ~clk;

    assign scl_line = ~scl_low;
    assign sda_line = ~(sda_low | sda_oe);

    i2c_blockcfg_slave uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_line),
        .sda_i     (sda_line),
        .sda_oe_o  (sda_oe),
        .ro_byte_i (RO),
        .cfg_o     (cfg)
    );

    int total = 0, failed = 0;
    bit done = 0;

    typedef struct { string req; logic [7:0] val; } item_t;
    item_t      exp_q[$];
    logic [7:0] obs_q[$];
    logic [7:0] mdl [6];

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    // scoreboard monitor: compares each bus result with the queued expectation
    initial forever begin
        @(negedge clk);
        while (obs_q.size() > 0) begin
            logic [7:0] o;
            item_t e;
            o = obs_q.pop_front();
            if (exp_q.size() == 0) begin
                total++; failed++;
                $display("FAIL scoreboard: actual %h expected none", o);
            end else begin
                e = exp_q.pop_front();
                chk(e.req, {56'h0, o}, {56'h0, e.val});
            end
        end
    end

    int viol = 0;
    logic p_scl = 1'b1, p_oe = 1'b0;
    always @(posedge clk) begin
        if (rst_n && scl_line && p_scl && sda_oe != p_oe) viol++;
        p_scl <= scl_line;
        p_oe  <= sda_oe;
    end

    task automatic qw(); repeat (Q) @(negedge clk); endtask
    task automatic expect_item(input string r, input logic [7:0] v);
        item_t it; it.req = r; it.val = v; exp_q.push_back(it);
    endtask

    task automatic m_start();
        sda_low = 0; scl_low = 0; qw();
        sda_low = 1; qw();
        scl_low = 1; qw();
    endtask
    task automatic m_stop();
        sda_low = 1; qw();
        scl_low = 0; qw();
        sda_low = 0; qw();
    endtask
    task automatic send_bit(input logic b);
        sda_low = ~b; qw();
        scl_low = 0; qw(); qw();
        scl_low = 1; qw();
    endtask
    task automatic recv_bit(output logic b);
        sda_low = 0; qw();
        scl_low = 0; qw();
        b = sda_line; qw();
        scl_low = 1; qw();
    endtask

    // send a byte MSB first; ack item 00, nack item 01
    task automatic m_write(input logic [7:0] v, input logic want_ack, input string r);
        logic a;
        expect_item(r, want_ack ? 8'h00 : 8'h01);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        obs_q.push_back({7'h0, a});
    endtask
    task automatic m_read(input logic give_ack, input logic [7:0] v, input string r);
        logic [7:0] d;
        expect_item(r, v);
        for (int i = 7; i >= 0; i--) recv_bit(d[i]);
        send_bit(~give_ack);
        obs_q.push_back(d);
    endtask

    function automatic logic [47:0] mdl_vec();
        logic [47:0] v;
        for (int k = 0; k < 6; k++) v[k*8 +: 8] = mdl[k];
        return v;
    endfunction

    task automatic read_all(input string r);
        m_start();
        m_write(8'hD3, 1, "R1 read address");
        m_read(1, 8'd7, "R6 count byte");
        for (int k = 0; k < 6; k++) m_read(1, mdl[k], r);
        m_read(1, RO, "R7 read-only byte");
        m_read(1, 8'hFF, "R7 tail byte");
        m_read(0, 8'hFF, "R7 tail byte");
        m_stop();
    endtask

    initial begin
        for (int k = 0; k < 6; k++) mdl[k] = DEF[k*8 +: 8];
        repeat (5) @(negedge clk);
        chk("R9 reset sda released", {63'h0, sda_oe}, 64'h0);
        rst_n = 1;
        repeat (5) @(negedge clk);
        chk("R9 reset defaults", {16'h0, cfg}, {16'h0, DEF});

        read_all("R9 default readback R10");

        // dummy bytes only
        m_start();
        m_write(8'hD2, 1, "R1 write address");
        m_write(8'hAA, 1, "R2 command acked");
        m_write(8'hBB, 1, "R2 count acked");
        m_stop();
        chk("R2 dummies discarded", {16'h0, cfg}, {16'h0, mdl_vec()});

        // full write plus overrun
        m_start();
        m_write(8'hD2, 1, "R1 write address");
        m_write(8'h01, 1, "R2 command acked");
        m_write(8'h02, 1, "R2 count acked");
        for (int k = 0; k < 6; k++) begin
            m_write(8'hA0 + 8'(k) * 8'h11, 1, "R3 data acked");
            mdl[k] = 8'hA0 + 8'(k) * 8'h11;
        end
        m_write(8'hEE, 1, "R5 overrun acked");
        m_write(8'h77, 1, "R5 overrun acked");
        m_stop();
        chk("R3 registers loaded", {16'h0, cfg}, {16'h0, mdl_vec()});
        read_all("R5 readback after overrun");

        // short write, then a byte cut at three bits
        m_start();
        m_write(8'hD2, 1, "R1 write address");
        m_write(8'h00, 1, "R2 command acked");
        m_write(8'h00, 1, "R2 count acked");
        m_write(8'h5B, 1, "R4 data acked");
        mdl[0] = 8'h5B;
        send_bit(1); send_bit(1); send_bit(1);
        m_stop();
        chk("R4 partial load", {16'h0, cfg}, {16'h0, mdl_vec()});

        // foreign addresses
        m_start();
        m_write(8'hA4, 0, "R1 foreign address nack");
        m_write(8'h00, 0, "R1 no ack after foreign address");
        m_stop();
        m_start();
        m_write(8'hD0, 0, "R1 neighbour address nack");
        m_write(8'h99, 0, "R1 no ack after neighbour address");
        m_stop();
        chk("R1 foreign writes ignored", {16'h0, cfg}, {16'h0, mdl_vec()});

        // master nack aborts a read
        m_start();
        m_write(8'hD3, 1, "R1 read address");
        m_read(1, 8'd7, "R6 count byte");
        m_read(0, mdl[0], "R8 byte before nack");
        qw();
        chk("R8 sda released after nack", {63'h0, sda_oe}, 64'h0);
        m_read(0, 8'hFF, "R8 bus idle after nack");
        m_stop();

        repeat (10) @(negedge clk);
        chk("R10 no sda change while scl high", viol, 0);
        chk("scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

endmodule